// File: doc/BRIEF.md
# Counted Loop Branch Resolver

This unit settles the outcome of a counted-loop branch in one pipeline step. It receives a snapshot of the machine state that the instruction needs: the instruction pointer, the pointer of the next sequential instruction and the count register. It also receives the address and operand sizes, the loop variant, the zero flag, the 8-bit signed displacement, the code-segment bounds, the processor mode and a lock-prefix indicator. It returns the updated count, whether the branch is taken, the pointer to fetch next, and two fault indications.

The count is taken from the low 16, 32 or 64 bits of the count register and decremented before it is tested. The loop variant then combines the zero flag with a nonzero-count test. A taken target is formed by adding the sign-extended displacement to the instruction pointer and truncating the sum to the operand size. The target is then checked in the way the processor mode requires. When a fault is raised, the instruction has no architectural effect. The zero flag is only read and is never reported back.

Each instruction enters through a valid/ready request channel and leaves through a valid/ready result channel, with a single register stage between them. The producer must hold every request field steady while `in_valid` is high and `in_ready` is low. The unit holds every result field steady while `out_valid` is high and `out_ready` is low. A stalled result stops new requests from being accepted, unless that result drains on the same edge.

Top module: `loop_branch_resolver`

## Requirements
- R1: The active count is the low 16, 32 or 64 bits of `in_count`, selected by `in_asize` (0=16, 1=32, 2 or 3=64). It is decremented modulo its width. `out_count` carries the decremented value in those bits and passes the bits above them through unchanged.
- R2: For variant code 0, the branch is taken exactly when the decremented active count is nonzero. Code 3 behaves like code 0.
- R3: For variant code 1, the branch is taken when the zero flag is 1 and the decremented count is nonzero. For variant code 2, it is taken when the zero flag is 0 and the decremented count is nonzero.
- R4: A taken branch gives `out_next_ip` = `in_ip` + sign-extended `in_disp` (range -128..+127), and `out_taken`=1. A branch that is not taken gives `out_next_ip` = `in_seq_ip`.
- R5: The taken target is truncated to the operand size given by `in_osize` (0=16 bits, 1=32 bits, 2 or 3=64 bits).
- R6: In protected mode (`in_mode` 1, and also 3), with operand size 32 or 64, a taken target below `in_cs_base` or above `in_cs_limit` raises `out_gp`. Both bounds themselves are legal. With a 16-bit operand size there is no segment check.
- R7: In real-address mode (`in_mode` 0), a taken target above 0xFFFF raises `out_gp`.
- R8: In 64-bit mode (`in_mode` 2), a taken target whose bits 63:47 are not all equal raises `out_gp`.
- R9: `in_lock`=1 raises `out_ud` in every mode, whatever the branch outcome, and suppresses `out_gp`. Under any fault: `out_taken`=0, `out_next_ip`=`in_ip`, and `out_count`=`in_count`.
- R10: A request is accepted on an edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` after that same edge. `in_ready` equals `!out_valid || out_ready`. The result is held unchanged while it is stalled.
- R11: During and right after reset, `out_valid` and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this edge |
| in_ip | input | 64 | Pointer of the loop instruction |
| in_seq_ip | input | 64 | Pointer of the following instruction |
| in_count | input | 64 | Full count register |
| in_asize | input | 2 | Address size code |
| in_osize | input | 2 | Operand size code |
| in_variant | input | 2 | Loop variant code |
| in_zf | input | 1 | Zero flag (read only) |
| in_disp | input | 8 | Signed displacement |
| in_cs_base | input | 64 | Code-segment lower bound |
| in_cs_limit | input | 64 | Code-segment upper bound |
| in_mode | input | 2 | Processor mode code |
| in_lock | input | 1 | Lock prefix present |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_count | output | 64 | Updated count register |
| out_taken | output | 1 | Branch taken |
| out_next_ip | output | 64 | Pointer to fetch next |
| out_gp | output | 1 | General-protection fault |
| out_ud | output | 1 | Undefined-opcode fault |

## Verification
Each result is due on the first clock edge after its request is accepted, and it stays on the result port until the edge on which `out_ready` is seen high. The bench drives inputs on the falling edge and lets them settle. It then pushes a behavioural prediction into a queue on every accepting cycle, and pops and compares the prediction on every draining cycle, so each comparison lands exactly on the cycle in which that result is consumed. While `out_ready` is deliberately held low, the bench also compares the outputs against their previous-cycle snapshot, which checks the hold rule.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_64X = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    VAR_PLAIN   = 2'd0,
    VAR_WHILE_Z = 2'd1,
    VAR_WHILE_NZ = 2'd2,
    VAR_ALT     = 2'd3
  } variant_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

endpackage

// File: rtl/lbr_count_unit.sv
module lbr_count_unit
  import lbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  size_e             size_i,
  input  logic [XLEN-1:0]   count_i,
  output logic [XLEN-1:0]   count_o,
  output logic              nonzero_o
);

  localparam logic [XLEN-1:0] MASK16 = {{(XLEN-16){1'b0}}, {16{1'b1}}};
  localparam logic [XLEN-1:0] MASK32 = {{(XLEN-32){1'b0}}, {32{1'b1}}};
  localparam logic [XLEN-1:0] MASKW  = {XLEN{1'b1}};

  logic [XLEN-1:0] width_mask;
  logic [XLEN-1:0] active;
  logic [XLEN-1:0] dec;

  always_comb begin
    unique case (size_i)
      SZ_16:   width_mask = MASK16;
      SZ_32:   width_mask = MASK32;
      default: width_mask = MASKW;
    endcase
    active    = count_i & width_mask;
    dec       = (active - {{(XLEN-1){1'b0}}, 1'b1}) & width_mask;
    count_o   = (count_i & ~width_mask) | dec;
    nonzero_o = |dec;
  end

endmodule

// File: rtl/lbr_cond_unit.sv
module lbr_cond_unit
  import lbr_pkg::*;
(
  input  variant_e variant_i,
  input  logic     zf_i,
  input  logic     nonzero_i,
  output logic     take_o
);

  always_comb begin
    unique case (variant_i)
      VAR_WHILE_Z:  take_o = nonzero_i &  zf_i;
      VAR_WHILE_NZ: take_o = nonzero_i & ~zf_i;
      default:      take_o = nonzero_i;
    endcase
  end

endmodule

// File: rtl/lbr_target_unit.sv
module lbr_target_unit
  import lbr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int DISP_W  = 8,
  parameter int VA_BITS = 48
) (
  input  logic [XLEN-1:0]   ip_i,
  input  logic [DISP_W-1:0] disp_i,
  input  size_e             osize_i,
  input  mode_e             mode_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   limit_i,
  input  logic              take_i,
  input  logic              lock_i,
  output logic [XLEN-1:0]   target_o,
  output logic              gp_o,
  output logic              ud_o
);

  localparam int REAL_TOP = 16;
  localparam logic [XLEN-1:0] OMASK16 = {{(XLEN-16){1'b0}}, {16{1'b1}}};
  localparam logic [XLEN-1:0] OMASK32 = {{(XLEN-32){1'b0}}, {32{1'b1}}};

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] raw_sum;
  logic            canonical;
  logic            seg_viol;
  logic            real_viol;

  assign disp_ext = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign raw_sum  = ip_i + disp_ext;

  always_comb begin
    unique case (osize_i)
      SZ_16:   target_o = raw_sum & OMASK16;
      SZ_32:   target_o = raw_sum & OMASK32;
      default: target_o = raw_sum;
    endcase
  end

  generate
    if (VA_BITS < XLEN) begin : g_canon
      logic [XLEN-VA_BITS:0] upper;
      assign upper     = target_o[XLEN-1:VA_BITS-1];
      assign canonical = (&upper) | ~(|upper);
    end else begin : g_flat
      assign canonical = 1'b1;
    end
  endgenerate

  assign seg_viol  = (osize_i != SZ_16) &&
                     ((target_o < base_i) || (target_o > limit_i));
  assign real_viol = |target_o[XLEN-1:REAL_TOP];

  always_comb begin
    ud_o = lock_i;
    gp_o = 1'b0;
    if (!lock_i && take_i) begin
      unique case (mode_i)
        MODE_REAL: gp_o = real_viol;
        MODE_LONG: gp_o = ~canonical;
        default:   gp_o = seg_viol;
      endcase
    end
  end

endmodule

// File: rtl/loop_branch_resolver.sv
module loop_branch_resolver
  import lbr_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int DISP_W  = 8,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_ip,
  input  logic [XLEN-1:0]   in_seq_ip,
  input  logic [XLEN-1:0]   in_count,
  input  logic [1:0]        in_asize,
  input  logic [1:0]        in_osize,
  input  logic [1:0]        in_variant,
  input  logic              in_zf,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [XLEN-1:0]   in_cs_base,
  input  logic [XLEN-1:0]   in_cs_limit,
  input  logic [1:0]        in_mode,
  input  logic              in_lock,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_count,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_next_ip,
  output logic              out_gp,
  output logic              out_ud
);

  logic [XLEN-1:0] new_count;
  logic            cnt_nonzero;
  logic            take;
  logic [XLEN-1:0] target;
  logic            gp;
  logic            ud;
  logic            fault;
  logic            accept;
  mode_e           r_mode;

  lbr_count_unit #(.XLEN(XLEN)) u_count (
    .size_i   (size_e'(in_asize)),
    .count_i  (in_count),
    .count_o  (new_count),
    .nonzero_o(cnt_nonzero)
  );

  lbr_cond_unit u_cond (
    .variant_i(variant_e'(in_variant)),
    .zf_i     (in_zf),
    .nonzero_i(cnt_nonzero),
    .take_o   (take)
  );

  lbr_target_unit #(.XLEN(XLEN), .DISP_W(DISP_W), .VA_BITS(VA_BITS)) u_target (
    .ip_i    (in_ip),
    .disp_i  (in_disp),
    .osize_i (size_e'(in_osize)),
    .mode_i  (mode_e'(in_mode)),
    .base_i  (in_cs_base),
    .limit_i (in_cs_limit),
    .take_i  (take),
    .lock_i  (in_lock),
    .target_o(target),
    .gp_o    (gp),
    .ud_o    (ud)
  );

  assign fault    = gp | ud;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_count   <= '0;
      out_taken   <= 1'b0;
      out_next_ip <= '0;
      out_gp      <= 1'b0;
      out_ud      <= 1'b0;
      r_mode      <= MODE_REAL;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_count   <= fault ? in_count : new_count;
      out_taken   <= take & ~fault;
      out_next_ip <= fault ? in_ip : (take ? target : in_seq_ip);
      out_gp      <= gp;
      out_ud      <= ud;
      r_mode      <= mode_e'(in_mode);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_ip) &&
      $stable(out_count) && $stable(out_taken) && $stable(out_gp) && $stable(out_ud));

  assert_fault_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_gp || out_ud) |-> !out_taken);

  assert_single_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_gp, out_ud}));

  assert_real_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken && r_mode == MODE_REAL |-> out_next_ip[XLEN-1:16] == '0);

  assert_canonical_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken && r_mode == MODE_LONG |->
      ((&out_next_ip[XLEN-1:VA_BITS-1]) || !(|out_next_ip[XLEN-1:VA_BITS-1])));

endmodule

// File: tb/loop_branch_resolver_bench.sv
module loop_branch_resolver_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ip = '0, in_seq_ip = '0, in_count = '0;
  logic [1:0]  in_asize = '0, in_osize = '0, in_variant = '0, in_mode = '0;
  logic        in_zf = 1'b0, in_lock = 1'b0;
  logic [7:0]  in_disp = '0;
  logic [63:0] in_cs_base = '0, in_cs_limit = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_count, out_next_ip;
  logic        out_taken, out_gp, out_ud;

  always #5 clk = ~clk;

  loop_branch_resolver u_loop_branch_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ip(in_ip), .in_seq_ip(in_seq_ip), .in_count(in_count),
    .in_asize(in_asize), .in_osize(in_osize), .in_variant(in_variant),
    .in_zf(in_zf), .in_disp(in_disp), .in_cs_base(in_cs_base),
    .in_cs_limit(in_cs_limit), .in_mode(in_mode), .in_lock(in_lock),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
    .out_taken(out_taken), .out_next_ip(out_next_ip), .out_gp(out_gp),
    .out_ud(out_ud)
  );

  typedef struct {
    logic [63:0] ip, seq, count, base, limit;
    logic [1:0]  asize, osize, variant, mode;
    logic        zf, lock;
    logic [7:0]  disp;
  } stim_t;

  typedef struct {
    logic [63:0] count, next_ip;
    logic        taken, gp, ud, fault;
    logic [1:0]  variant, mode, osize;
  } exp_t;

  stim_t stims[$];
  exp_t  exps[$];
  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(stim_t s);
    exp_t e;
    logic [63:0] m, dec, raw, tgt, om;
    logic nz, tk, canon;
    m   = (s.asize == 0) ? 64'hFFFF : (s.asize == 1) ? 64'hFFFF_FFFF : '1;
    dec = ((s.count & m) - 64'd1) & m;
    nz  = dec != 0;
    if (s.variant == 1)      tk = nz && s.zf;
    else if (s.variant == 2) tk = nz && !s.zf;
    else                     tk = nz;
    raw = s.ip + {{56{s.disp[7]}}, s.disp};
    om  = (s.osize == 0) ? 64'hFFFF : (s.osize == 1) ? 64'hFFFF_FFFF : '1;
    tgt = raw & om;
    canon = (tgt[63:47] == '0) || (tgt[63:47] == '1);
    e.ud = s.lock;
    e.gp = 1'b0;
    if (!s.lock && tk) begin
      if (s.mode == 0)      e.gp = tgt > 64'hFFFF;
      else if (s.mode == 2) e.gp = !canon;
      else                  e.gp = (s.osize != 0) && (tgt < s.base || tgt > s.limit);
    end
    e.fault   = e.gp || e.ud;
    e.taken   = tk && !e.fault;
    e.next_ip = e.fault ? s.ip : (tk ? tgt : s.seq);
    e.count   = e.fault ? s.count : ((s.count & ~m) | dec);
    e.variant = s.variant;
    e.mode    = s.mode;
    e.osize   = s.osize;
    return e;
  endfunction

  task automatic add(input logic [63:0] ip, input logic [63:0] count,
                     input logic [1:0] asz, input logic [1:0] osz,
                     input logic [1:0] vr, input logic zf, input logic [7:0] disp,
                     input logic [1:0] md, input logic lk,
                     input logic [63:0] base, input logic [63:0] limit);
    stim_t s;
    s.ip = ip; s.seq = ip + 64'd2; s.count = count; s.asize = asz; s.osize = osz;
    s.variant = vr; s.zf = zf; s.disp = disp; s.mode = md; s.lock = lk;
    s.base = base; s.limit = limit;
    stims.push_back(s);
  endtask

  task automatic apply(stim_t s);
    in_ip = s.ip; in_seq_ip = s.seq; in_count = s.count; in_asize = s.asize;
    in_osize = s.osize; in_variant = s.variant; in_zf = s.zf; in_disp = s.disp;
    in_mode = s.mode; in_lock = s.lock; in_cs_base = s.base; in_cs_limit = s.limit;
  endtask

  task automatic compare(exp_t e);
    string tt;
    string gt;
    tt = (e.variant == 1 || e.variant == 2) ? "R3 taken" : "R2 taken";
    gt = (e.mode == 0) ? "R7 gp" : (e.mode == 2) ? "R8 gp" : "R6 gp";
    check("R1 count", out_count, e.count);
    check(tt, {63'd0, out_taken}, {63'd0, e.taken});
    if (e.fault)             check("R9 next_ip", out_next_ip, e.next_ip);
    else if (e.osize != 2)   check("R5 next_ip", out_next_ip, e.next_ip);
    else                     check("R4 next_ip", out_next_ip, e.next_ip);
    check(gt, {63'd0, out_gp}, {63'd0, e.gp});
    check("R9 ud", {63'd0, out_ud}, {63'd0, e.ud});
  endtask

  initial begin
    logic        stalled;
    logic [63:0] snap_cnt, snap_ip;
    logic [2:0]  snap_flags;
    int          cycles;
    stalled = 1'b0; snap_cnt = '0; snap_ip = '0; snap_flags = '0; cycles = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: held in reset
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 out_count", out_count, 64'd0);
    check("R11 out_next_ip", out_next_ip, 64'd0);
    check("R11 flags", {61'd0, out_taken, out_gp, out_ud}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after", {63'd0, out_valid}, 64'd0);
    check("R10 in_ready idle", {63'd0, in_ready}, 64'd1);

    // R1/R2 count boundaries
    add(64'h1000, 64'd1, 2'd2, 2'd2, 2'd0, 1'b0, 8'hF0, 2'd2, 1'b0, 0, 0);
    add(64'h1000, 64'hABCD_0000, 2'd0, 2'd2, 2'd0, 1'b0, 8'hF0, 2'd2, 1'b0, 0, 0);
    add(64'h1000, 64'h1_0000_0001, 2'd1, 2'd2, 2'd0, 1'b0, 8'hF0, 2'd2, 1'b0, 0, 0);
    add(64'h1000, 64'h1_0000_0001, 2'd2, 2'd2, 2'd3, 1'b0, 8'hF0, 2'd2, 1'b0, 0, 0);
    add(64'h1000, 64'd0, 2'd3, 2'd2, 2'd0, 1'b0, 8'h7F, 2'd2, 1'b0, 0, 0);
    // R3 zero-flag variants
    add(64'h2000, 64'd5, 2'd1, 2'd1, 2'd1, 1'b1, 8'h80, 2'd1, 1'b0, 0, 64'hFFFF);
    add(64'h2000, 64'd5, 2'd1, 2'd1, 2'd1, 1'b0, 8'h80, 2'd1, 1'b0, 0, 64'hFFFF);
    add(64'h2000, 64'd5, 2'd1, 2'd1, 2'd2, 1'b0, 8'h80, 2'd1, 1'b0, 0, 64'hFFFF);
    add(64'h2000, 64'd5, 2'd1, 2'd1, 2'd2, 1'b1, 8'h80, 2'd1, 1'b0, 0, 64'hFFFF);
    add(64'h2000, 64'd1, 2'd1, 2'd1, 2'd1, 1'b1, 8'h80, 2'd1, 1'b0, 0, 64'hFFFF);
    // R5 16-bit wrap
    add(64'hFFF0, 64'd9, 2'd0, 2'd0, 2'd0, 1'b0, 8'h7F, 2'd1, 1'b0, 64'h10000, 64'h20000);
    add(64'hFFFF_FFF0, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h7F, 2'd2, 1'b0, 0, 0);
    // R6 segment bounds
    add(64'h3000, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h10, 2'd1, 1'b0, 64'h100, 64'h3010);
    add(64'h3000, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h11, 2'd1, 1'b0, 64'h100, 64'h3010);
    add(64'h3000, 64'd9, 2'd1, 2'd2, 2'd0, 1'b0, 8'hF0, 2'd3, 1'b0, 64'h2FF0, 64'h4000);
    add(64'h3000, 64'd9, 2'd1, 2'd2, 2'd0, 1'b0, 8'hEF, 2'd1, 1'b0, 64'h2FF0, 64'h4000);
    add(64'h3000, 64'd1, 2'd1, 2'd1, 2'd0, 1'b0, 8'h11, 2'd1, 1'b0, 64'h100, 64'h3010);
    // R7 real mode
    add(64'hFF80, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h7F, 2'd0, 1'b0, 0, 0);
    add(64'hFF81, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h7F, 2'd0, 1'b0, 0, 0);
    add(64'hFF81, 64'd9, 2'd0, 2'd0, 2'd0, 1'b0, 8'h7F, 2'd0, 1'b0, 0, 0);
    // R8 canonical boundary
    add(64'h0000_7FFF_FFFF_FFF0, 64'd9, 2'd2, 2'd2, 2'd0, 1'b0, 8'h0F, 2'd2, 1'b0, 0, 0);
    add(64'h0000_7FFF_FFFF_FFF0, 64'd9, 2'd2, 2'd2, 2'd0, 1'b0, 8'h10, 2'd2, 1'b0, 0, 0);
    add(64'hFFFF_8000_0000_0010, 64'd9, 2'd2, 2'd2, 2'd0, 1'b0, 8'hF0, 2'd2, 1'b0, 0, 0);
    add(64'hFFFF_8000_0000_0010, 64'd9, 2'd2, 2'd2, 2'd0, 1'b0, 8'hEF, 2'd2, 1'b0, 0, 0);
    // R9 lock, including a branch that is not taken
    add(64'h4000, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h04, 2'd0, 1'b1, 0, 0);
    add(64'h4000, 64'd1, 2'd1, 2'd1, 2'd0, 1'b0, 8'h04, 2'd2, 1'b1, 0, 0);
    add(64'hFF81, 64'd9, 2'd1, 2'd1, 2'd0, 1'b0, 8'h7F, 2'd0, 1'b1, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rip;
      rip = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : {32'd0, $urandom_range(0, 32'h3_0000)};
      add(rip, {$urandom_range(0, 3) == 0 ? 32'd0 : $urandom, 32'($urandom_range(0, 3))},
          2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
          2'($urandom), ($urandom_range(0, 15) == 0), {32'd0, $urandom_range(0, 32'h1_0000)},
          {32'd0, $urandom_range(32'h1_0000, 32'h3_0000)});
    end

    while ((stims.size() > 0 || exps.size() > 0) && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (stalled) begin
        // R10: stalled result must not move
        check("R10 hold valid", {63'd0, out_valid}, 64'd1);
        check("R10 hold count", out_count, snap_cnt);
        check("R10 hold next_ip", out_next_ip, snap_ip);
        check("R10 hold flags", {61'd0, out_taken, out_gp, out_ud}, {61'd0, snap_flags});
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (stims.size() > 0) begin
        apply(stims[0]);
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      check("R10 in_ready", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exps.size() == 0) check("R10 spurious out_valid", 64'd1, 64'd0);
        else begin
          compare(exps[0]);
          void'(exps.pop_front());
        end
      end else if (!out_valid && exps.size() > 0 && in_ready && !in_valid) begin
        check("R10 missing result", 64'd0, 64'd1);
        void'(exps.pop_front());
      end
      stalled    = out_valid && !out_ready;
      snap_cnt   = out_count;
      snap_ip    = out_next_ip;
      snap_flags = {out_taken, out_gp, out_ud};
      if (in_valid && in_ready) begin
        exps.push_back(predict(stims[0]));
        void'(stims.pop_front());
      end
    end
    if (cycles >= 20000) check("watchdog R10", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule